// File: doc/BRIEF.md
# Bit Scan and Bit Test Unit

A purely combinational datapath slice that performs single-bit work on a register-width word. Two scan operations locate a set bit in the source operand. The forward scan finds the lowest set bit and the reverse scan finds the highest. Both report through the zero flag whether the source held any set bit at all. Four bit-test operations read one bit of the destination operand into the carry flag. Three of them also rewrite that bit: they invert it, clear it or set it.

The unit sits beside an execution stage's adder and shifter. Each cycle the issue logic presents an opcode, the destination value, the source value and an optional immediate. In the same cycle the unit returns a result, a write strobe for the destination, and values for the carry and zero flags, each with its own update strobe. The bit position for the test operations comes either from the source register or from the immediate, chosen by a select input. Only the low log2(W) bits of the position are used.

Top module: `bsu_top`

## Requirements
- R1: Opcode 1 (forward scan) with a nonzero source drives res_o with the index of the lowest set bit of src_i, zero-extended, and raises res_we_o.
- R2: Opcode 2 (reverse scan) with a nonzero source drives res_o with the index of the highest set bit of src_i, zero-extended, and raises res_we_o.
- R3: Either scan raises zf_we_o. It drives zf_o high exactly when src_i is zero, and in that case res_we_o stays low and res_o is zero.
- R4: Scans keep cf_we_o low and bit-test opcodes keep zf_we_o low, so neither touches the other's flag.
- R5: All bit-test opcodes (3 test, 4 complement, 5 clear, 6 set) raise cf_we_o and drive cf_o with the selected destination bit as it was before the operation.
- R6: Opcode 3 (plain test) keeps res_we_o low and drives res_o equal to dst_i.
- R7: Opcodes 4, 5 and 6 raise res_we_o and drive res_o equal to dst_i with only the selected bit inverted (4), forced to 0 (5) or forced to 1 (6).
- R8: The bit position is imm_i when sel_imm_i is 1 and src_i when it is 0, in either case taken modulo W (its low 5 bits for W=32).
- R9: Opcodes 0 and 7 are idle: every output, result and flags included, is zero.
- R10: Outputs follow inputs in the same cycle, with no register between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 3 | Operation code (0/7 idle, 1 forward scan, 2 reverse scan, 3 test, 4 complement, 5 clear, 6 set) |
| sel_imm_i | input | 1 | Bit position taken from imm_i when 1, from src_i when 0 |
| dst_i | input | W | Destination operand value |
| src_i | input | W | Source operand: scan input or register bit position |
| imm_i | input | IMMW | Immediate bit position |
| res_o | output | W | Result to write back to the destination |
| res_we_o | output | 1 | Destination write strobe |
| cf_o | output | 1 | Carry flag value |
| cf_we_o | output | 1 | Carry flag update strobe |
| zf_o | output | 1 | Zero flag value |
| zf_we_o | output | 1 | Zero flag update strobe |

## Verification
The bench goes after the edges of the scan: single bits at both ends and at every position, a full word, and an all-zero source. A scanner with the priority reversed would return the wrong end of a multi-bit word, and one that wrote back on zero would corrupt the destination. For the bit operations it uses positions 0 and 31, register values of 32 and above, and an immediate that differs from the register value. A design that did not wrap the index, or picked the wrong operand, would then flip the wrong bit or report the wrong carry. It also checks that plain test never asserts the write strobe and that no operation raises the strobe of a flag it does not own.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

   typedef enum logic [2:0] {
      OP_IDLE  = 3'd0,
      OP_SCANF = 3'd1,
      OP_SCANR = 3'd2,
      OP_TEST  = 3'd3,
      OP_TCOMP = 3'd4,
      OP_TCLR  = 3'd5,
      OP_TSET  = 3'd6,
      OP_IDLE2 = 3'd7
   } bsu_op_e;

   typedef enum logic [1:0] {
      BM_KEEP = 2'd0,
      BM_FLIP = 2'd1,
      BM_ZERO = 2'd2,
      BM_ONE  = 2'd3
   } bsu_bitmode_e;

   function automatic logic is_scan(bsu_op_e op);
      return (op == OP_SCANF) || (op == OP_SCANR);
   endfunction

   function automatic logic is_btest(bsu_op_e op);
      return (op == OP_TEST) || (op == OP_TCOMP) || (op == OP_TCLR) || (op == OP_TSET);
   endfunction

endpackage

// File: rtl/bsu_index_sel.sv
module bsu_index_sel #(
   parameter int W    = 32,
   parameter int IMMW = 8,
   localparam int IDXW = $clog2(W)
) (
   input  logic            sel_imm_i,
   input  logic [W-1:0]    src_i,
   input  logic [IMMW-1:0] imm_i,
   output logic [IDXW-1:0] idx_o
);

   logic [W-1:0] pick;

   initial begin
      if (IMMW > W) $error("bsu_index_sel: IMMW must not exceed W");
   end

   always_comb begin
      pick  = sel_imm_i ? W'(imm_i) : src_i;
      idx_o = IDXW'(pick % W);
   end

endmodule

// File: rtl/bsu_scan.sv
module bsu_scan #(
   parameter int W       = 32,
   parameter bit REVERSE = 1'b0,
   localparam int IDXW = $clog2(W)
) (
   input  logic [W-1:0]    vec_i,
   output logic            any_o,
   output logic [IDXW-1:0] idx_o
);

   logic [W-1:0]    ordered;
   logic [IDXW-1:0] low_pos;

   generate
      if (REVERSE) begin : g_rev
         for (genvar g = 0; g < W; g++) begin : g_flip
            assign ordered[g] = vec_i[W-1-g];
         end
      end else begin : g_fwd
         assign ordered = vec_i;
      end
   endgenerate

   always_comb begin
      low_pos = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (ordered[i]) low_pos = IDXW'(i);
      end
   end

   assign any_o = |vec_i;

   generate
      if (REVERSE) begin : g_rev_idx
         assign idx_o = IDXW'(W - 1) - low_pos;
      end else begin : g_fwd_idx
         assign idx_o = low_pos;
      end
   endgenerate

endmodule

// File: rtl/bsu_bitop.sv
module bsu_bitop #(
   parameter int W = 32,
   localparam int IDXW = $clog2(W)
) (
   input  bsu_pkg::bsu_bitmode_e mode_i,
   input  logic [W-1:0]          dst_i,
   input  logic [IDXW-1:0]       idx_i,
   output logic                  old_o,
   output logic [W-1:0]          new_o
);

   import bsu_pkg::*;

   logic [W-1:0] mask;

   always_comb begin
      mask  = W'(1) << idx_i;
      old_o = dst_i[idx_i];
      unique case (mode_i)
         BM_FLIP: new_o = dst_i ^ mask;
         BM_ZERO: new_o = dst_i & ~mask;
         BM_ONE:  new_o = dst_i | mask;
         default: new_o = dst_i;
      endcase
   end

endmodule

// File: rtl/bsu_top.sv
module bsu_top #(
   parameter int W    = 32,
   parameter int IMMW = 8,
   localparam int IDXW = $clog2(W)
) (
   input  logic [2:0]      op_i,
   input  logic            sel_imm_i,
   input  logic [W-1:0]    dst_i,
   input  logic [W-1:0]    src_i,
   input  logic [IMMW-1:0] imm_i,
   output logic [W-1:0]    res_o,
   output logic            res_we_o,
   output logic            cf_o,
   output logic            cf_we_o,
   output logic            zf_o,
   output logic            zf_we_o
);

   import bsu_pkg::*;

   initial begin
      if (W < 2 || (1 << IDXW) != W) $error("bsu_top: W must be a power of two, at least 2");
      if (IMMW < IDXW) $error("bsu_top: IMMW too narrow for a full bit position");
   end

   bsu_op_e         op;
   bsu_bitmode_e    mode;
   logic [IDXW-1:0] bit_idx;
   logic            fwd_any, rev_any;
   logic [IDXW-1:0] fwd_idx, rev_idx;
   logic            old_bit;
   logic [W-1:0]    new_dst;

   assign op = bsu_op_e'(op_i);

   always_comb begin
      unique case (op)
         OP_TCOMP: mode = BM_FLIP;
         OP_TCLR:  mode = BM_ZERO;
         OP_TSET:  mode = BM_ONE;
         default:  mode = BM_KEEP;
      endcase
   end

   bsu_index_sel #(.W(W), .IMMW(IMMW)) u_idx (
      .sel_imm_i (sel_imm_i),
      .src_i     (src_i),
      .imm_i     (imm_i),
      .idx_o     (bit_idx)
   );

   bsu_scan #(.W(W), .REVERSE(1'b0)) u_scan_fwd (
      .vec_i (src_i),
      .any_o (fwd_any),
      .idx_o (fwd_idx)
   );

   bsu_scan #(.W(W), .REVERSE(1'b1)) u_scan_rev (
      .vec_i (src_i),
      .any_o (rev_any),
      .idx_o (rev_idx)
   );

   bsu_bitop #(.W(W)) u_bitop (
      .mode_i (mode),
      .dst_i  (dst_i),
      .idx_i  (bit_idx),
      .old_o  (old_bit),
      .new_o  (new_dst)
   );

   always_comb begin
      res_o    = '0;
      res_we_o = 1'b0;
      cf_o     = 1'b0;
      cf_we_o  = 1'b0;
      zf_o     = 1'b0;
      zf_we_o  = 1'b0;
      unique case (op)
         OP_SCANF: begin
            zf_we_o  = 1'b1;
            zf_o     = ~fwd_any;
            res_we_o = fwd_any;
            res_o    = fwd_any ? W'(fwd_idx) : '0;
         end
         OP_SCANR: begin
            zf_we_o  = 1'b1;
            zf_o     = ~rev_any;
            res_we_o = rev_any;
            res_o    = rev_any ? W'(rev_idx) : '0;
         end
         OP_TEST: begin
            cf_we_o = 1'b1;
            cf_o    = old_bit;
            res_o   = dst_i;
         end
         OP_TCOMP, OP_TCLR, OP_TSET: begin
            cf_we_o  = 1'b1;
            cf_o     = old_bit;
            res_o    = new_dst;
            res_we_o = 1'b1;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/bsu_checker.sv
module bsu_checker #(
   parameter int W    = 32,
   parameter int IMMW = 8,
   localparam int IDXW = $clog2(W)
) (
   input logic [2:0]      op_i,
   input logic            sel_imm_i,
   input logic [W-1:0]    dst_i,
   input logic [W-1:0]    src_i,
   input logic [IMMW-1:0] imm_i,
   input logic [W-1:0]    res_o,
   input logic            res_we_o,
   input logic            cf_o,
   input logic            cf_we_o,
   input logic            zf_o,
   input logic            zf_we_o
);

   logic [IDXW-1:0] pos;
   logic [W-1:0]    below;
   logic [W-1:0]    diff;
   logic [IDXW-1:0] rpos;

   always_comb begin
      pos   = sel_imm_i ? imm_i[IDXW-1:0] : src_i[IDXW-1:0];
      rpos  = res_o[IDXW-1:0];
      below = (W'(1) << rpos) - W'(1);
      diff  = res_o ^ dst_i;

      if (op_i == 3'd1 && res_we_o)
         a_r1_lowest_set: assert (src_i[rpos] && (src_i & below) == '0);
      if (op_i == 3'd2 && res_we_o)
         a_r2_highest_set: assert (src_i[rpos] && ((src_i >> rpos) >> 1) == '0);
      if ((op_i == 3'd1 || op_i == 3'd2))
         a_r3_zero_no_write: assert (zf_we_o && (zf_o == (src_i == '0)) && (zf_o == !res_we_o));
      if (op_i == 3'd1 || op_i == 3'd2)
         a_r4_scan_keeps_cf: assert (!cf_we_o);
      if (op_i >= 3'd3 && op_i <= 3'd6)
         a_r4_test_keeps_zf: assert (!zf_we_o);
      if (op_i >= 3'd3 && op_i <= 3'd6)
         a_r5_carry_old_bit: assert (cf_we_o && cf_o == dst_i[pos]);
      if (op_i == 3'd3)
         a_r6_test_no_write: assert (!res_we_o && diff == '0);
      if (op_i >= 3'd4 && op_i <= 3'd6)
         a_r7_single_bit: assert (res_we_o && (diff & ~(W'(1) << pos)) == '0);
      if (op_i == 3'd0 || op_i == 3'd7)
         a_r9_idle_quiet: assert (!res_we_o && !cf_we_o && !zf_we_o && res_o == '0);
   end

endmodule

bind bsu_top bsu_checker #(.W(W), .IMMW(IMMW)) u_chk (
   .op_i      (op_i),
   .sel_imm_i (sel_imm_i),
   .dst_i     (dst_i),
   .src_i     (src_i),
   .imm_i     (imm_i),
   .res_o     (res_o),
   .res_we_o  (res_we_o),
   .cf_o      (cf_o),
   .cf_we_o   (cf_we_o),
   .zf_o      (zf_o),
   .zf_we_o   (zf_we_o)
);

// File: tb/tb_bsu_top.sv
`timescale 1ns/1ps
module tb_bsu_top;

   localparam int W = 32;
   localparam int IMMW = 8;

   typedef struct packed {
      logic [3:0]  req;
      logic [2:0]  op;
      logic        sel;
      logic [31:0] dst;
      logic [31:0] src;
      logic [7:0]  imm;
      logic [31:0] res;
      logic        we;
      logic        cf;
      logic        cfwe;
      logic        zf;
      logic        zfwe;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t VECS [NV] = '{
      // R1 forward scan
      '{4'd1, 3'd1, 1'b0, 32'h0, 32'h0000_0008, 8'd0, 32'd3,  1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
      '{4'd1, 3'd1, 1'b0, 32'h0, 32'h8000_0000, 8'd0, 32'd31, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
      '{4'd1, 3'd1, 1'b0, 32'h0, 32'hFFFF_FFFF, 8'd0, 32'd0,  1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
      '{4'd1, 3'd1, 1'b0, 32'h0, 32'h00F0_F000, 8'd0, 32'd12, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
      // R3 zero source, forward
      '{4'd3, 3'd1, 1'b0, 32'h1234_5678, 32'h0, 8'd0, 32'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
      // R2 reverse scan
      '{4'd2, 3'd2, 1'b0, 32'h0, 32'h0000_0001, 8'd0, 32'd0,  1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
      '{4'd2, 3'd2, 1'b0, 32'h0, 32'h8000_0001, 8'd0, 32'd31, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
      '{4'd2, 3'd2, 1'b0, 32'h0, 32'h00F0_F000, 8'd0, 32'd23, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
      // R3 zero source, reverse
      '{4'd3, 3'd2, 1'b0, 32'hFFFF_FFFF, 32'h0, 8'd0, 32'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
      // R6 plain test
      '{4'd6, 3'd3, 1'b0, 32'h0000_0010, 32'd4, 8'd0, 32'h0000_0010, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
      // R7 complement, clear, set
      '{4'd7, 3'd4, 1'b0, 32'h0000_0010, 32'd4, 8'd0, 32'h0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
      '{4'd7, 3'd5, 1'b0, 32'hFFFF_FFFF, 32'd31, 8'd0, 32'h7FFF_FFFF, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
      '{4'd7, 3'd5, 1'b0, 32'h0, 32'd3, 8'd0, 32'h0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
      '{4'd7, 3'd6, 1'b1, 32'h8000_0000, 32'd0, 8'd31, 32'h8000_0000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
      // R8 index wrap and immediate select
      '{4'd8, 3'd4, 1'b1, 32'h0, 32'd0, 8'd37, 32'h0000_0020, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
      '{4'd8, 3'd6, 1'b0, 32'h0, 32'h0000_0020, 8'd0, 32'h0000_0001, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
      '{4'd8, 3'd3, 1'b1, 32'h0000_0100, 32'd0, 8'd8, 32'h0000_0100, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
      // R9 idle opcodes
      '{4'd9, 3'd0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'hFF, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      '{4'd9, 3'd7, 1'b1, 32'hFFFF_FFFF, 32'h1, 8'd1, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2 clk = ~clk;

   logic [2:0]      op_i = 3'd0;
   logic            sel_imm_i = 1'b0;
   logic [W-1:0]    dst_i = '0;
   logic [W-1:0]    src_i = '0;
   logic [IMMW-1:0] imm_i = '0;
   logic [W-1:0]    res_o;
   logic            res_we_o, cf_o, cf_we_o, zf_o, zf_we_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   bsu_top #(.W(W), .IMMW(IMMW)) dut (
      .op_i(op_i), .sel_imm_i(sel_imm_i), .dst_i(dst_i), .src_i(src_i), .imm_i(imm_i),
      .res_o(res_o), .res_we_o(res_we_o), .cf_o(cf_o), .cf_we_o(cf_we_o),
      .zf_o(zf_o), .zf_we_o(zf_we_o)
   );

   function automatic logic [36:0] outs();
      return {res_o, res_we_o, cf_o, cf_we_o, zf_o, zf_we_o};
   endfunction

   task automatic chk(input string tag, input logic [36:0] act, input logic [36:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [2:0] op, input logic sel, input logic [31:0] d,
                        input logic [31:0] s, input logic [7:0] im);
      @(negedge clk);
      op_i = op; sel_imm_i = sel; dst_i = d; src_i = s; imm_i = im;
      #1;
   endtask

   initial begin
      repeat (2) @(negedge clk);
      rst = 1'b0;
      #1;
      // R9 idle state out of reset, all inputs zero
      chk("R9 idle at start", outs(), 37'h0);

      foreach (VECS[k]) begin
         drive(VECS[k].op, VECS[k].sel, VECS[k].dst, VECS[k].src, VECS[k].imm);
         chk($sformatf("R%0d vector %0d", VECS[k].req, k), outs(),
             {VECS[k].res, VECS[k].we, VECS[k].cf, VECS[k].cfwe, VECS[k].zf, VECS[k].zfwe});
      end

      // R1 R2: single set bit at every position, both scan directions
      for (int i = 0; i < W; i++) begin
         drive(3'd1, 1'b0, 32'h0, 32'h1 << i, 8'd0);
         chk($sformatf("R1 single bit %0d", i), outs(), {32'(i), 5'b10001});
         drive(3'd2, 1'b0, 32'h0, 32'h1 << i, 8'd0);
         chk($sformatf("R2 single bit %0d", i), outs(), {32'(i), 5'b10001});
      end

      // R7 R5: set bit at each position from register index in range 32..63
      for (int i = 0; i < W; i++) begin
         drive(3'd6, 1'b0, 32'h0, 32'(i + 32), 8'd0);
         chk($sformatf("R8 wrapped set %0d", i), outs(), {32'h1 << i, 5'b10100});
      end

      // R10: outputs change in the same cycle, without waiting for a clock edge
      @(negedge clk);
      op_i = 3'd5; sel_imm_i = 1'b0; dst_i = 32'hFFFF_FFFF; src_i = 32'd0;
      #0.5;
      chk("R10 same cycle response", outs(), {32'hFFFF_FFFE, 5'b11100});

      // R4: scans leave carry strobe low even when the source is all ones
      drive(3'd2, 1'b0, 32'h0, 32'hFFFF_FFFF, 8'd0);
      chk("R4 scan carry untouched", {36'h0, cf_we_o}, 37'h0);

      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (20000) @(posedge clk);
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule